// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns a 2N-bit product one clock after the operands are sampled. A grid of AND gates first forms every partial-product bit. Bit (i,j) is A[i] AND B[j], and it lands in column i+j. A reduction tree then squeezes every column down to at most two bits. That tree is built from (3,2) counters (full adders) and (2,2) counters (half adders). A ripple-carry adder sums the two surviving rows, and the result is captured in an output register.

The tree is planned backward from the two-row result. The column-height ceilings are 2, 3, 4, 6, 9, 13 and so on, each one being 3/2 of the one below it, rounded down. The tree takes as many stages as there are ceilings below N. Each stage works only on columns that would otherwise exceed its ceiling. It uses as few counters as that takes, and passes every other bit through untouched. The sum of a counter stays in its own column and its carry moves one column up. All of this is decided at elaboration from N, by functions in the package that drive generate loops.

The block is meant as a combinational multiplier core with one register at its output. It has no signed mode and no pipelining inside the tree.

Top module: `dadda_mult`

## Requirements
- R1: One rising edge after the operands are sampled, `product` equals the unsigned product op_a × op_b in 2N bits.
- R2: While `rst` is high at a rising edge, `product` becomes zero after that edge, whatever the operand values.
- R3: If either operand is zero, `product` is zero after the next edge.
- R4: With both operands at their largest value, 2^N−1, `product` equals (2^N−1)², which is 3969 for N = 6, with no wrap.
- R5: If one operand equals one, `product` equals the other operand, zero-extended to 2N bits.
- R6: Operand changes between rising edges leave `product` unchanged until the next rising edge.
- R7: The sum of the final two rows never produces a set bit at position 2N or above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| product | output | 2N | Registered unsigned product |

## Verification
A miswired counter, a carry sent to the wrong column, or a dropped pass-through bit shows up as a wrong product. It appears one edge after the first operand pair whose partial products cross that counter, and only for those pairs. A sweep over every operand pair at N = 6 therefore exposes any such fault within a few thousand cycles. A wrong stage plan that leaves a column taller than two rows shows up as a missing bit in the product. A wrong plan that lets the sum spill past bit 2N−1 trips the overflow check in the same cycle the adder sees it.

// File: rtl/dadda_pkg.sv
`timescale 1ns/1ps
package dadda_pkg;

    // Column capacity of the elaboration-time planner (N up to 64)
    localparam int MAX_COLS = 130;

    typedef struct packed {
        logic carry;
        logic sum;
    } cnt_out_t;

    // (3,2) counter
    function automatic cnt_out_t count3(input logic x, input logic y, input logic z);
        cnt_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // (2,2) counter
    function automatic cnt_out_t count2(input logic x, input logic y);
        cnt_out_t r;
        r.sum   = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

    // Height ceiling k in the growing sequence 2,3,4,6,9,...
    function automatic int stage_limit(input int k);
        int d;
        d = 2;
        for (int i = 0; i < k; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Number of reduction stages for an n-bit square multiplier
    function automatic int num_stages(input int n);
        int s;
        s = 0;
        for (int k = 0; k < 40; k++)
            if (stage_limit(k) < n) s = k + 1;
        return s;
    endfunction

    // Plan query: what=0 column height entering stage s,
    // what=1 full-adder count, what=2 half-adder count in stage s.
    function automatic int col_plan(input int n, input int s, input int c, input int what);
        int h  [0:MAX_COLS-1];
        int nh [0:MAX_COLS-1];
        int w, ns, cin, ex, fa, ha, res;
        w   = 2 * n + 1;
        ns  = num_stages(n);
        res = 0;
        for (int col = 0; col < MAX_COLS; col++) begin
            if (col > 2 * n - 2)  h[col] = 0;
            else if (col < n)     h[col] = col + 1;
            else                  h[col] = 2 * n - 1 - col;
            nh[col] = 0;
        end
        for (int st = 0; st <= s; st++) begin
            cin = 0;
            for (int col = 0; col < w; col++) begin
                if (st < ns) ex = h[col] + cin - stage_limit(ns - 1 - st);
                else         ex = 0;
                if (ex < 0) ex = 0;
                fa = ex / 2;
                ha = ex % 2;
                if (st == s && col == c)
                    res = (what == 0) ? h[col] : ((what == 1) ? fa : ha);
                nh[col] = h[col] - 2 * fa - ha + cin;
                cin = fa + ha;
            end
            for (int col = 0; col < w; col++) h[col] = nh[col];
        end
        return res;
    endfunction

    // Offset of column c inside the flat bit vector of level s
    function automatic int col_off(input int n, input int s, input int c);
        int sum;
        sum = 0;
        for (int col = 0; col < c; col++) sum += col_plan(n, s, col, 0);
        return sum;
    endfunction

    function automatic int lvl_size(input int n, input int s);
        return col_off(n, s, 2 * n + 1);
    endfunction

    // Offset of level s inside the storage of all levels
    function automatic int lvl_base(input int n, input int s);
        int sum;
        sum = 0;
        for (int t = 0; t < s; t++) sum += lvl_size(n, t);
        return sum;
    endfunction

endpackage

// File: rtl/pp_grid.sv
`timescale 1ns/1ps
module pp_grid
    import dadda_pkg::*;
#(
    parameter int N     = 6,
    parameter int OUT_W = 36
) (
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    output logic [OUT_W-1:0] bits
);
    // Bit (i,j) goes to column i+j, stacked by ascending i
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            localparam int C   = i + j;
            localparam int LO  = (C > N - 1) ? C - (N - 1) : 0;
            localparam int POS = col_off(N, 0, C) + i - LO;
            assign bits[POS] = a[i] & b[j];
        end
    end
endmodule

// File: rtl/dadda_stage.sv
`timescale 1ns/1ps
module dadda_stage
    import dadda_pkg::*;
#(
    parameter int N     = 6,
    parameter int STG   = 0,
    parameter int IN_W  = 36,
    parameter int OUT_W = 36
) (
    input  logic [IN_W-1:0]  bits_in,
    output logic [OUT_W-1:0] bits_out
);
    localparam int W = 2 * N + 1;

    for (genvar c = 0; c < W; c++) begin : g_col
        localparam int H    = col_plan(N, STG, c, 0);
        localparam int NFA  = col_plan(N, STG, c, 1);
        localparam int NHA  = col_plan(N, STG, c, 2);
        localparam int USED = 3 * NFA + 2 * NHA;
        localparam int NCNT = NFA + NHA;
        localparam int IB   = col_off(N, STG, c);
        localparam int OB   = col_off(N, STG + 1, c);
        // Where this column's carries land in column c+1 of the next level
        localparam int H1   = (c + 1 < W) ? col_plan(N, STG, c + 1, 0) : 0;
        localparam int FA1  = (c + 1 < W) ? col_plan(N, STG, c + 1, 1) : 0;
        localparam int HA1  = (c + 1 < W) ? col_plan(N, STG, c + 1, 2) : 0;
        localparam int CB   = (c + 1 < W) ?
                              col_off(N, STG + 1, c + 1) + FA1 + HA1 + (H1 - 3 * FA1 - 2 * HA1) : 0;

        for (genvar k = 0; k < NFA; k++) begin : g_fa
            cnt_out_t r;
            assign r = count3(bits_in[IB + 3*k], bits_in[IB + 3*k + 1], bits_in[IB + 3*k + 2]);
            assign bits_out[OB + k] = r.sum;
            if (c + 1 < W) begin : g_cy
                assign bits_out[CB + k] = r.carry;
            end
        end

        if (NHA == 1) begin : g_ha
            cnt_out_t r;
            assign r = count2(bits_in[IB + 3*NFA], bits_in[IB + 3*NFA + 1]);
            assign bits_out[OB + NFA] = r.sum;
            if (c + 1 < W) begin : g_cy
                assign bits_out[CB + NFA] = r.carry;
            end
        end

        for (genvar p = USED; p < H; p++) begin : g_pass
            assign bits_out[OB + NCNT + (p - USED)] = bits_in[IB + p];
        end
    end
endmodule

// File: rtl/rca_adder.sv
`timescale 1ns/1ps
module rca_adder #(
    parameter int W = 13
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   sum
);
    logic [W:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = x[i] ^ y[i] ^ cy[i];
        assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
    end
    assign sum[W] = cy[W];
endmodule

// File: rtl/dadda_mult.sv
`timescale 1ns/1ps
module dadda_mult
    import dadda_pkg::*;
#(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    output logic [2*N-1:0] product
);
    localparam int W     = 2 * N + 1;
    localparam int NS    = num_stages(N);
    localparam int TOTAL = lvl_base(N, NS + 1);
    localparam int FBASE = lvl_base(N, NS);

    logic [TOTAL-1:0] lvl;
    logic [W-1:0]     row_x;
    logic [W-1:0]     row_y;
    logic [W:0]       full_sum;
    logic [1:0]       spill;

    pp_grid #(.N(N), .OUT_W(lvl_size(N, 0))) u_pp (
        .a    (op_a),
        .b    (op_b),
        .bits (lvl[lvl_base(N, 0) +: lvl_size(N, 0)])
    );

    for (genvar s = 0; s < NS; s++) begin : g_stage
        localparam int IW = lvl_size(N, s);
        localparam int OW = lvl_size(N, s + 1);
        dadda_stage #(.N(N), .STG(s), .IN_W(IW), .OUT_W(OW)) u_stage (
            .bits_in  (lvl[lvl_base(N, s) +: IW]),
            .bits_out (lvl[lvl_base(N, s + 1) +: OW])
        );
    end

    // Two surviving rows feed the carry-propagate adder
    for (genvar c = 0; c < W; c++) begin : g_final
        localparam int H   = col_plan(N, NS, c, 0);
        localparam int OFF = FBASE + col_off(N, NS, c);
        if (H >= 1) begin : g_x
            assign row_x[c] = lvl[OFF];
        end else begin : g_x0
            assign row_x[c] = 1'b0;
        end
        if (H >= 2) begin : g_y
            assign row_y[c] = lvl[OFF + 1];
        end else begin : g_y0
            assign row_y[c] = 1'b0;
        end
    end

    rca_adder #(.W(W)) u_cpa (
        .x   (row_x),
        .y   (row_y),
        .sum (full_sum)
    );

    assign spill = full_sum[W:2*N];

    always_ff @(posedge clk) begin
        if (rst) product <= '0;
        else     product <= full_sum[2*N-1:0];
    end

    p_reset_clears_r2: assert property (@(posedge clk)
        rst |=> product == '0);

    p_zero_operand_r3: assert property (@(posedge clk) disable iff (rst)
        (op_a == '0 || op_b == '0) |=> product == '0);

    p_identity_r5: assert property (@(posedge clk) disable iff (rst)
        (op_b == N'(1)) |=> product == (2*N)'($past(op_a)));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(op_a) && $stable(op_b) && !$past(rst)) |=> $stable(product));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        spill == 2'b00);

endmodule

// File: tb/sim_dadda_mult.sv
`timescale 1ns/1ps
module sim_dadda_mult;
    localparam int N = 6;

    typedef struct packed {
        logic [N-1:0]   a;
        logic [N-1:0]   b;
        logic [2*N-1:0] p;
        logic [3:0]     req;
    } vec_t;

    localparam vec_t TBL [0:9] = '{
        '{6'd0,  6'd45, 12'd0,    4'd3},   // R3 zero multiplicand
        '{6'd45, 6'd0,  12'd0,    4'd3},   // R3 zero multiplier
        '{6'd63, 6'd63, 12'd3969, 4'd4},   // R4 both at maximum, no wrap (R7)
        '{6'd63, 6'd62, 12'd3906, 4'd4},   // R4 near maximum
        '{6'd63, 6'd1,  12'd63,   4'd5},   // R5 identity on op_b
        '{6'd1,  6'd37, 12'd37,   4'd5},   // R5 identity on op_a
        '{6'd1,  6'd1,  12'd1,    4'd5},   // R5 one times one
        '{6'd42, 6'd21, 12'd882,  4'd1},   // R1 mixed pattern
        '{6'd21, 6'd42, 12'd882,  4'd1},   // R1 swapped operands
        '{6'd32, 6'd32, 12'd1024, 4'd1}    // R1 single high bits
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   op_a = '0;
    logic [N-1:0]   op_b = '0;
    logic [2*N-1:0] product;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dadda_mult #(.N(N)) u0 (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );

    task automatic check(input string req, input logic [2*N-1:0] exp);
        checks++;
        if (product !== exp) begin
            fails++;
            $display("FAIL %s: product=%0d expected=%0d", req, product, exp);
        end
    endtask

    // Drive on a falling edge, sample on the next falling edge
    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
    endtask

    initial begin
        // R2: reset holds product at zero despite nonzero operands
        op_a = 6'd63;
        op_b = 6'd63;
        @(negedge clk);
        @(negedge clk);
        check("R2", '0);

        rst = 1'b0;
        apply(6'd5, 6'd7);
        check("R1", 12'd35);

        foreach (TBL[i]) begin
            apply(TBL[i].a, TBL[i].b);
            check($sformatf("R%0d", TBL[i].req), TBL[i].p);
        end

        // R1: every operand pair against a behavioural product
        for (int x = 0; x < (1 << N); x++) begin
            for (int y = 0; y < (1 << N); y++) begin
                apply(N'(x), N'(y));
                check("R1", (2*N)'(x * y));
            end
        end

        // R6: operand change between edges does not reach the product
        apply(6'd10, 6'd11);
        check("R6", 12'd110);
        op_a = 6'd3;
        op_b = 6'd3;
        #1;
        check("R6", 12'd110);
        @(negedge clk);
        check("R6", 12'd9);

        // R2: reset in mid-run clears a loaded product
        apply(6'd63, 6'd63);
        check("R4", 12'd3969);
        rst = 1'b1;
        @(negedge clk);
        check("R2", '0);
        @(negedge clk);
        check("R2", '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 12'd3969);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: finished=%0d expected=1", done);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule